// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes frames from a PS/2 keyboard and runs entirely on the fast system clock. The slow PS/2 clock line is never used to clock a flop. It is synchronized and sampled like any other input, and a falling-edge detector on the synchronized copy decides when a frame bit is taken. A small state machine steps through the start bit, eight data bits, the parity bit and the stop bit. It then either presents the byte with a one-cycle strobe or reports a framing error.

The receiver checks the start bit, odd parity and the stop bit. A mid-frame inactivity timer pulls the machine back to idle after a glitch or a truncated frame, so the next good frame is received aligned. The control and the datapath are separate modules that talk through a small bundle of strobes.

Top module: `kbd_frame_rx`

## Requirements
- R1: While the active-low reset `rstN` is low, and after it is released until the first completed frame, `keyCode` is 0 and `keyValid` and `frameErr` are 0.
- R2: Both raw PS/2 lines pass through `SYNC_STAGES` (at least two) system-clock flops. The frame state advances only on a detected falling edge of the synchronized PS/2 clock (previous sample 1, current sample 0). Changes on the data line while the PS/2 clock is high have no effect.
- R3: Data bits arrive least significant bit first. Each new bit enters at bit 7 of a right-shifting register, so the first data bit received ends at bit 0 of `keyCode`.
- R4: A start bit sampled as 1 is discarded. The machine stays idle and the next falling edge is again treated as a start-bit candidate.
- R5: Parity is odd: the eight data bits plus the parity bit must hold an odd number of ones. On a mismatch `frameErr` pulses for one cycle, no `keyValid` is given and `keyCode` keeps its old value.
- R6: A stop bit sampled as 0 gives a one-cycle `frameErr` pulse and no `keyValid`.
- R7: `keyValid` is high for exactly one system-clock cycle per good frame, and never together with `frameErr`.
- R8: `keyCode` changes only in the cycle in which `keyValid` is high.
- R9: If a frame is in progress and `TIMEOUT_CYCLES` system clocks pass with no falling edge, the machine returns to idle without raising `keyValid` or `frameErr`. The following frame is received correctly.
- R10: A 3-bit index counts the data bits and returns to 0 after the eighth. The shift register and the index are cleared when a frame ends, so back-to-back frames each decode to their own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ps2ClkRaw | input | 1 | Raw PS/2 clock line, asynchronous |
| ps2DataRaw | input | 1 | Raw PS/2 data line, asynchronous |
| keyCode | output | 8 | Last correctly received byte |
| keyValid | output | 1 | One-cycle strobe when a good frame completes |
| frameErr | output | 1 | One-cycle strobe when a frame fails parity or stop checks |

## Verification
The bench sends every one of the 256 byte values back to back. A bit-order or shift-direction mistake would show up as mirrored codes, and an index that was not cleared would corrupt every frame after the first. Single frames then carry a wrong parity bit, a zero stop bit, a lone start-bit edge with the line high, and a truncated frame followed by a long gap. A receiver that ignored any of these checks would raise `keyValid` for a bad frame or decode the next good frame out of alignment. One frame also wiggles the data line while the PS/2 clock is high, which catches logic that samples on anything other than the falling edge.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_PARITY = 2'd2,
    ST_STOP   = 2'd3
  } rxState_t;

  // Strobes issued by the control towards the datapath
  typedef struct packed {
    logic shiftBit;   // take a data bit into the shift register
    logic capParity;  // latch the parity bit
    logic finish;     // stop bit present: validate and commit
    logic flush;      // abandon the frame (timeout)
  } rxStrobe_t;

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clkRaw,
  input  logic dataRaw,
  output logic bitNow,
  output logic fallEdge
);

  logic [SYNC_STAGES-1:0] clkChain;
  logic [SYNC_STAGES-1:0] dataChain;
  logic [1:0]             clkPair;   // [1] previous, [0] current
  logic                   dataAligned;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            clkChain[g]  <= 1'b1;
            dataChain[g] <= 1'b1;
          end else begin
            clkChain[g]  <= clkRaw;
            dataChain[g] <= dataRaw;
          end
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            clkChain[g]  <= 1'b1;
            dataChain[g] <= 1'b1;
          end else begin
            clkChain[g]  <= clkChain[g-1];
            dataChain[g] <= dataChain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPair     <= 2'b11;
      dataAligned <= 1'b1;
    end else begin
      clkPair     <= {clkPair[0], clkChain[SYNC_STAGES-1]};
      dataAligned <= dataChain[SYNC_STAGES-1];
    end
  end

  assign fallEdge = (clkPair == 2'b10);
  assign bitNow   = dataAligned;

  // R2: an edge is a single-cycle event
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> !fallEdge);

  initial begin
    p_stages_r2: assert (SYNC_STAGES >= 2);
  end

endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fallEdge,
  input  logic      bitIn,
  input  logic      idxLast,
  output rxStrobe_t strb
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  rxState_t         state;
  rxState_t         nextState;
  logic [CNT_W-1:0] quietCnt;
  logic             timeoutHit;

  assign timeoutHit = (state != ST_IDLE) && !fallEdge && (quietCnt == CNT_LAST);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (fallEdge && !bitIn) nextState = ST_DATA;
      end
      ST_DATA: begin
        if (fallEdge) begin
          strb.shiftBit = 1'b1;
          if (idxLast) nextState = ST_PARITY;
        end
      end
      ST_PARITY: begin
        if (fallEdge) begin
          strb.capParity = 1'b1;
          nextState      = ST_STOP;
        end
      end
      ST_STOP: begin
        if (fallEdge) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (timeoutHit) begin
      strb      = '0;
      strb.flush = 1'b1;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      quietCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || fallEdge || timeoutHit) quietCnt <= '0;
      else                                            quietCnt <= quietCnt + 1'b1;
    end
  end

  // R2: no edge and no timeout means the state holds
  p_hold_no_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!fallEdge && !timeoutHit) |=> $stable(state));

  // R4: a high start bit leaves the machine idle
  p_start_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && fallEdge && bitIn) |=> (state == ST_IDLE));

  // R9: the quiet counter never passes its limit
  p_timer_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt < CNT_W'(TIMEOUT_CYCLES));

  // R9: an expired timer returns to idle
  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> (state == ST_IDLE));

  // R2: at most one strobe per cycle
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/kbd_rx_dp.sv
module kbd_rx_dp
  import kbd_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic                 bitIn,
  output logic                 idxLast,
  output logic [DATA_BITS-1:0] keyCode,
  output logic                 keyValid,
  output logic                 frameErr
);

  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] shiftReg;
  logic [IDX_W-1:0]     idx;
  logic                 parBit;
  logic                 parityOk;

  assign idxLast  = (idx == IDX_TOP);
  assign parityOk = ^{shiftReg, parBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      idx      <= '0;
      parBit   <= 1'b0;
      keyCode  <= '0;
      keyValid <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      keyValid <= 1'b0;
      frameErr <= 1'b0;
      if (strb.flush) begin
        shiftReg <= '0;
        idx      <= '0;
      end else if (strb.shiftBit) begin
        shiftReg <= {bitIn, shiftReg[DATA_BITS-1:1]};
        idx      <= idxLast ? '0 : idx + 1'b1;
      end
      if (strb.capParity) parBit <= bitIn;
      if (strb.finish) begin
        if (bitIn && parityOk) begin
          keyCode  <= shiftReg;
          keyValid <= 1'b1;
        end else begin
          frameErr <= 1'b1;
        end
        shiftReg <= '0;
        idx      <= '0;
      end
    end
  end

  // R7: the strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid);

  // R7: success and error never coincide
  p_valid_err_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(keyValid && frameErr));

  // R8: the output byte moves only with the strobe
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |-> $stable(keyCode));

  // R10: index wraps after the last data bit
  p_idx_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftBit && idxLast && !strb.flush) |=> (idx == '0));

  // R10: a finished frame leaves the datapath cleared
  p_clear_after_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (idx == '0 && shiftReg == '0));

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2ClkRaw,
  input  logic       ps2DataRaw,
  output logic [7:0] keyCode,
  output logic       keyValid,
  output logic       frameErr
);

  logic      bitNow;
  logic      fallEdge;
  logic      idxLast;
  rxStrobe_t strb;

  kbd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .clkRaw   (ps2ClkRaw),
    .dataRaw  (ps2DataRaw),
    .bitNow   (bitNow),
    .fallEdge (fallEdge)
  );

  kbd_rx_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .fallEdge (fallEdge),
    .bitIn    (bitNow),
    .idxLast  (idxLast),
    .strb     (strb)
  );

  kbd_rx_dp #(.DATA_BITS(8)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIn    (bitNow),
    .idxLast  (idxLast),
    .keyCode  (keyCode),
    .keyValid (keyValid),
    .frameErr (frameErr)
  );

  // R1: nothing is reported while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!keyValid && !frameErr && keyCode == 8'h00));

endmodule

// File: tb/sim_kbd_frame_rx.sv
`timescale 1ns/1ps
module sim_kbd_frame_rx;

  localparam int HP      = 10;   // system clocks per PS/2 half period
  localparam int TIMEOUT = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ps2Clk = 1'b1;
  logic       ps2Data = 1'b1;
  logic [7:0] keyCode;
  logic       keyValid;
  logic       frameErr;

  int checks = 0;
  int failures = 0;
  int validCnt = 0;
  int errCnt = 0;
  int pulseViol = 0;
  logic [7:0] lastCode = 8'h00;
  logic prevValid = 1'b0;
  bit done = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  kbd_frame_rx #(.SYNC_STAGES(2), .TIMEOUT_CYCLES(TIMEOUT)) u0 (
    .clk(clk), .rstN(rstN), .ps2ClkRaw(ps2Clk), .ps2DataRaw(ps2Data),
    .keyCode(keyCode), .keyValid(keyValid), .frameErr(frameErr)
  );

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (keyValid) begin
        validCnt++;
        lastCode = keyCode;
      end
      if (frameErr) errCnt++;
      if (keyValid && (prevValid || frameErr)) pulseViol++;
      prevValid = keyValid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected < 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic sendBit(input logic b, input bit wiggle);
    if (wiggle) begin
      ps2Data = ~b;
      repeat (HP/2) @(negedge clk);
      ps2Data = b;
      repeat (HP - HP/2) @(negedge clk);
    end else begin
      ps2Data = b;
      repeat (HP) @(negedge clk);
    end
    ps2Clk = 1'b0;
    repeat (HP) @(negedge clk);
    ps2Clk = 1'b1;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic startB,
                           input logic parFlip, input logic stopB, input bit wiggle);
    sendBit(startB, wiggle);
    for (int i = 0; i < 8; i++) sendBit(d[i], wiggle);
    sendBit((~^d) ^ parFlip, wiggle);
    sendBit(stopB, wiggle);
    ps2Data = 1'b1;
    repeat (3*HP) @(negedge clk);
  endtask

  initial begin
    int v0;
    int e0;
    logic [7:0] c0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check("R1 keyCode in reset", keyCode, 0);
    check("R1 keyValid in reset", keyValid, 0);
    check("R1 frameErr in reset", frameErr, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 keyCode after release", keyCode, 0);
    check("R1 no strobes after release", validCnt + errCnt, 0);

    // R3 / R10: every byte, back to back
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b0, 1'b0, 1'b1, 0);
      check("R3 byte assembled LSB first", lastCode, b);
      check("R10 one strobe per frame", validCnt, b + 1);
    end
    check("R5 no errors on good frames", errCnt, 0);
    check("R7 strobe width", pulseViol, 0);

    // R5: wrong parity on several bytes
    for (int k = 0; k < 4; k++) begin
      v0 = validCnt; e0 = errCnt; c0 = lastCode;
      sendFrame(8'(8'h11 * (k + 1) + k), 1'b0, 1'b1, 1'b1, 0);
      check("R5 parity error flagged", errCnt, e0 + 1);
      check("R5 no strobe on parity error", validCnt, v0);
      check("R8 code held on parity error", keyCode, c0);
    end

    // R6: stop bit low
    v0 = validCnt; e0 = errCnt;
    sendFrame(8'h6E, 1'b0, 1'b0, 1'b0, 0);
    check("R6 stop error flagged", errCnt, e0 + 1);
    check("R6 no strobe on stop error", validCnt, v0);

    // R4: lone edge with a high start bit, then a good frame
    v0 = validCnt; e0 = errCnt;
    sendBit(1'b1, 0);
    repeat (2*HP) @(negedge clk);
    check("R4 high start gives no strobe", validCnt + errCnt, v0 + e0);
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1, 0);
    check("R4 next frame aligned", lastCode, 8'hA5);
    check("R4 next frame counted", validCnt, v0 + 1);
    check("R4 no error", errCnt, e0);

    // R9: truncated frame, gap past the timeout, then a good frame
    v0 = validCnt; e0 = errCnt;
    sendBit(1'b0, 0);
    sendBit(1'b1, 0);
    sendBit(1'b0, 0);
    sendBit(1'b1, 0);
    ps2Data = 1'b1;
    repeat (TIMEOUT + 100) @(negedge clk);
    check("R9 timeout silent", validCnt + errCnt, v0 + e0);
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b1, 0);
    check("R9 frame after timeout", lastCode, 8'h3C);
    check("R9 frame after timeout counted", validCnt, v0 + 1);
    check("R9 no error after timeout", errCnt, e0);

    // R2: data moves while the PS/2 clock is high
    v0 = validCnt;
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1, 1);
    check("R2 only falling edges sample", lastCode, 8'h5A);
    check("R2 strobe with wiggled data", validCnt, v0 + 1);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b1, 1);
    check("R2 second wiggled frame", lastCode, 8'hC3);

    check("R7 strobe width at end", pulseViol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule